// File: doc/BRIEF.md
# SPI Descriptor Chain Sequencer

This block walks a linked list of transfer descriptors kept in memory and hands each one to an SPI shift engine. A descriptor is six 32-bit words, 24 bytes in all. Descriptors sit back to back, so the next one always starts 24 bytes after the current one. Software writes the list base address and sets a go flag. The sequencer then fetches the six words, one memory read at a time, and pulses a start strobe to the engine with the decoded fields. It waits for the engine to report done and moves on. It stops after the descriptor whose end-of-chain flag is set, or on an error, or when software aborts it.

The start can also wait for an external frame-sync input. A config bit arms the start for the rising edge of that input, and another arms it for the falling edge. Completion and errors collect in a write-one-to-clear status register. An enable mask reduces that register to a single interrupt line. A one-bit ownership flag at offset 0 lets software agents claim and release the controller.

The control state machine has four states:
- `S_IDLE` waits for an armed start.
- `S_FETCH` holds a memory read until the response arrives.
- `S_LAUNCH` drives the one-cycle engine start.
- `S_RUN` waits for the engine's done.

Its transitions are:
- *fire*: IDLE→FETCH.
- *word*: FETCH→FETCH, after one of words 0 to 4.
- *sixth*: FETCH→LAUNCH.
- *fetch-error*: FETCH→IDLE.
- *dispatch*: LAUNCH→RUN.
- *advance*: RUN→FETCH, on a clean done without end of chain.
- *finish*: RUN→IDLE, on end of chain or an engine fault.
- *abort*: any busy state→IDLE.

Top module: `spi_desc_seq`

## Requirements
- R1: A descriptor is six consecutive 32-bit words at byte offsets 0, 4, 8, 12, 16 and 20 from its base:
  - start word;
  - bus word;
  - transmit address, low half then high half;
  - receive address, low half then high half.

  When `eng_start` is high, `eng_cmd`, `eng_bus`, `eng_tx_addr` and `eng_rx_addr` carry exactly these values.
- R2: A register write is decoded only when `reg_addr[1:0]` is 0. Writing offset 0x24 with bit 31 set while idle starts the chain at `{hi[ADDR_W-33:0], lo}`, where lo is the word last written at 0x20. Bit 31 is not part of the address. The same write while a chain is running is ignored.
- R3: At most one memory read is outstanding. `mem_req` and `mem_addr` stay unchanged until `mem_rsp_valid`. `eng_start` is a single-cycle pulse that follows the sixth word. No fetch happens between `eng_start` and `eng_done`.
- R4: If start-word bit 30 is set, a clean `eng_done` stops the sequencer and sets status bits 9 (ready), 10 (descriptor done) and 11 (chain done).
- R5: A clean `eng_done` on a descriptor without bit 30 sets status bit 10. Fetching then resumes 24 bytes further on.
- R6: Writing 0 to offset 0x24 while busy returns the sequencer to idle. After that there is no further `mem_req` or `eng_start`, and a later `eng_done` is ignored. The abort sets bit 9 only.
- R7: A fetch response with `mem_rsp_err` high sets status bits 8 and 9 and halts the chain. The descriptor being fetched is never dispatched.
- R8: A nonzero `eng_fault` with `eng_done` is ORed into status bits 7:0. It sets bit 9, does not set bit 10, and halts the chain.
- R9: The status register at 0x30 resets to 0. Writing ones clears the matching bits, and zero bits are left unchanged.
- R10: `irq` is the OR of (status AND enable). The enable register is at 0x34 and resets to 0.
- R11: Config register 0x04 bit 6 makes an armed start wait for a rising edge of `vsync`, and bit 7 for a falling edge. Before that edge there is no `mem_req`, and the opposite edge does not start the chain.
- R12: The ownership flag at 0x00 reads 1 after reset. A write stores `reg_wdata[0]` into it, so 0 claims the controller and 1 releases it. It reads back in bit 0.
- R13: Offsets 0x28 and 0x2C read the low 32 bits and the upper bits of the current descriptor's address. After a chain ends, that is the address of its last descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Descriptor word read request, held until response |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_err | input | 1 | Read response error |
| mem_rsp_data | input | 32 | Read response data |
| eng_start | output | 1 | One-cycle dispatch strobe to the shift engine |
| eng_cmd | output | 32 | Descriptor start word |
| eng_bus | output | 32 | Descriptor bus word |
| eng_tx_addr | output | 64 | Descriptor transmit address |
| eng_rx_addr | output | 64 | Descriptor receive address |
| eng_done | input | 1 | Engine finished the dispatched descriptor |
| eng_fault | input | 8 | Channel error flags, valid with eng_done |
| vsync | input | 1 | Asynchronous frame-sync start input |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The bench builds the block with `ADDR_W = 40` and `SYNC_STAGES = 2`. A narrow upper address half then holds a nonzero value, so both address readback words and the bit-31 masking are visible. The bench sweeps every chain length from 1 to 4 against memory latencies 0 to 2 and engine latencies 0 to 2, which gives 36 chains. Each fetch-to-dispatch spacing and back-to-back dispatch is therefore covered, and every forwarded field is compared with the arithmetic pattern the bench placed in memory. Directed cases cover these corners:
- a fetch error in mid-chain;
- an engine fault;
- an abort during a long engine run;
- a go written while busy;
- each trigger edge, including the opposite edge that must not start the chain.

// File: rtl/seq_pkg.sv
package seq_pkg;

    // Control states of the descriptor walker
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FETCH  = 2'd1,
        S_LAUNCH = 2'd2,
        S_RUN    = 2'd3
    } seq_state_t;

    // Descriptor geometry
    localparam int DESC_WORDS = 6;
    localparam int DESC_BYTES = DESC_WORDS * 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);

    // Register word indices (byte offset / 4)
    localparam logic [3:0] REG_SEM     = 4'd0;
    localparam logic [3:0] REG_CFG     = 4'd1;
    localparam logic [3:0] REG_LIST_LO = 4'd8;
    localparam logic [3:0] REG_LIST_HI = 4'd9;
    localparam logic [3:0] REG_CUR_LO  = 4'd10;
    localparam logic [3:0] REG_CUR_HI  = 4'd11;
    localparam logic [3:0] REG_STS     = 4'd12;
    localparam logic [3:0] REG_ENA     = 4'd13;

    // Field positions
    localparam int GO_BIT        = 31;
    localparam int EOC_BIT       = 30;
    localparam int CFG_RISE_BIT  = 6;
    localparam int CFG_FALL_BIT  = 7;

    // Status layout
    localparam int STS_W          = 12;
    localparam int FAULT_W        = 8;
    localparam int ST_DESC_ERR    = 8;
    localparam int ST_READY       = 9;
    localparam int ST_DESC_DONE   = 10;
    localparam int ST_CHAIN_DONE  = 11;

endpackage

// File: rtl/seq_vsync_edge.sv
module seq_vsync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_in,
    output logic rise,
    output logic fall
);
    // sync[0..SYNC_STAGES-1] resynchronise, extra stage keeps the previous value
    logic [SYNC_STAGES:0] sync_q;

    genvar g;
    generate
        for (g = 0; g <= SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= vsync_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    assign fall = ~sync_q[SYNC_STAGES-1] & sync_q[SYNC_STAGES];

endmodule

// File: rtl/seq_regs.sv
module seq_regs
    import seq_pkg::*;
#(
    parameter int ADDR_W = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [STS_W-1:0]  sts_set,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] list_base,
    output logic              go_req,
    output logic              abort_req,
    output logic              trig_rise_en,
    output logic              trig_fall_en,
    output logic              irq
);
    localparam int HI_W = ADDR_W - 32;

    logic             sem_free;
    logic [31:0]      cfg_q;
    logic [31:0]      lo_q;
    logic [HI_W-1:0]  hi_q;
    logic [STS_W-1:0] sts_q;
    logic [STS_W-1:0] ena_q;
    logic [STS_W-1:0] sts_clr;
    logic [3:0]       widx;
    logic             wr_ok;

    assign widx  = reg_addr[5:2];
    assign wr_ok = reg_we && (reg_addr[1:0] == 2'b00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sem_free <= 1'b1;
            cfg_q    <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
            ena_q    <= '0;
        end else if (wr_ok) begin
            case (widx)
                REG_SEM:     sem_free <= reg_wdata[0];
                REG_CFG:     cfg_q    <= reg_wdata;
                REG_LIST_LO: lo_q     <= reg_wdata;
                REG_LIST_HI: hi_q     <= reg_wdata[HI_W-1:0];
                REG_ENA:     ena_q    <= reg_wdata[STS_W-1:0];
                default:     ;
            endcase
        end
    end

    // write-one-to-clear; a set in the same cycle wins
    assign sts_clr = (wr_ok && widx == REG_STS) ? reg_wdata[STS_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~sts_clr) | sts_set;
    end

    assign go_req       = wr_ok && (widx == REG_LIST_HI) && reg_wdata[GO_BIT];
    assign abort_req    = wr_ok && (widx == REG_LIST_HI) && (reg_wdata == 32'd0);
    assign list_base    = {hi_q, lo_q};
    assign trig_rise_en = cfg_q[CFG_RISE_BIT];
    assign trig_fall_en = cfg_q[CFG_FALL_BIT];
    assign irq          = |(sts_q & ena_q);

    always_comb begin
        case (widx)
            REG_SEM:     reg_rdata = {31'd0, sem_free};
            REG_CFG:     reg_rdata = cfg_q;
            REG_LIST_LO: reg_rdata = lo_q;
            REG_LIST_HI: reg_rdata = 32'(hi_q);
            REG_CUR_LO:  reg_rdata = cur_addr[31:0];
            REG_CUR_HI:  reg_rdata = 32'(cur_addr[ADDR_W-1:32]);
            REG_STS:     reg_rdata = 32'(sts_q);
            REG_ENA:     reg_rdata = 32'(ena_q);
            default:     reg_rdata = 32'd0;
        endcase
    end

    // R9: clearing write with no simultaneous set leaves those bits at zero
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && widx == REG_STS && sts_set == '0)
            |=> ((sts_q & $past(reg_wdata[STS_W-1:0])) == '0));

    // R12: ownership flag follows the last write to it
    p_sem_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && widx == REG_SEM) |=> (sem_free == $past(reg_wdata[0])));

    // R10: interrupt only with some pending status
    p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sts_q != '0));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int ADDR_W = 63
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_req,
    input  logic               abort_req,
    input  logic [ADDR_W-1:0]  base_in,
    input  logic               trig_rise_en,
    input  logic               trig_fall_en,
    input  logic               vs_rise,
    input  logic               vs_fall,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rsp_valid,
    input  logic               mem_rsp_err,
    input  logic [31:0]        mem_rsp_data,
    output logic               eng_start,
    output logic [31:0]        eng_cmd,
    output logic [31:0]        eng_bus,
    output logic [63:0]        eng_tx_addr,
    output logic [63:0]        eng_rx_addr,
    input  logic               eng_done,
    input  logic [FAULT_W-1:0] eng_fault,
    output logic [STS_W-1:0]   sts_set,
    output logic [ADDR_W-1:0]  cur_addr
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    seq_state_t        state, state_nx;
    logic [ADDR_W-1:0] cur_base;
    logic [IDX_W-1:0]  idx;
    logic [31:0]       desc_q [DESC_WORDS];
    logic              armed;
    logic              fire;
    logic              accept;
    logic              eoc;
    logic              clean_done;

    assign fire = armed && (state == S_IDLE) &&
                  ((!trig_rise_en && !trig_fall_en) ||
                   (trig_rise_en && vs_rise) ||
                   (trig_fall_en && vs_fall));
    assign accept     = (state == S_FETCH) && mem_rsp_valid && !abort_req;
    assign eoc        = desc_q[0][EOC_BIT];
    assign clean_done = (state == S_RUN) && eng_done && !abort_req &&
                        (eng_fault == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (fire) state_nx = S_FETCH;
            S_FETCH: begin
                if (abort_req)            state_nx = S_IDLE;
                else if (mem_rsp_valid) begin
                    if (mem_rsp_err)          state_nx = S_IDLE;
                    else if (idx == LAST_IDX) state_nx = S_LAUNCH;
                end
            end
            S_LAUNCH: state_nx = abort_req ? S_IDLE : S_RUN;
            S_RUN: begin
                if (abort_req)                      state_nx = S_IDLE;
                else if (eng_done) begin
                    if (eng_fault != '0 || eoc)     state_nx = S_IDLE;
                    else                            state_nx = S_FETCH;
                end
            end
            default:  state_nx = S_IDLE;
        endcase
    end

    // outputs and status events
    always_comb begin
        mem_req   = 1'b0;
        eng_start = 1'b0;
        sts_set   = '0;
        unique case (state)
            S_IDLE:   ;
            S_FETCH: begin
                mem_req = 1'b1;
                if (accept && mem_rsp_err) begin
                    sts_set[ST_DESC_ERR] = 1'b1;
                    sts_set[ST_READY]    = 1'b1;
                end
            end
            S_LAUNCH: eng_start = 1'b1;
            S_RUN: begin
                if (eng_done && !abort_req) begin
                    sts_set[FAULT_W-1:0] = eng_fault;
                    if (eng_fault == '0) begin
                        sts_set[ST_DESC_DONE] = 1'b1;
                        if (eoc) begin
                            sts_set[ST_CHAIN_DONE] = 1'b1;
                            sts_set[ST_READY]      = 1'b1;
                        end
                    end else begin
                        sts_set[ST_READY] = 1'b1;
                    end
                end
            end
            default:  ;
        endcase
        if (abort_req && state != S_IDLE) sts_set[ST_READY] = 1'b1;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_base <= '0;
            idx      <= '0;
            armed    <= 1'b0;
            for (int i = 0; i < DESC_WORDS; i++) desc_q[i] <= '0;
        end else begin
            if (abort_req || fire)                armed <= 1'b0;
            else if (go_req && state == S_IDLE)   armed <= 1'b1;

            if (fire) begin
                cur_base <= base_in;
                idx      <= '0;
            end else if (accept && !mem_rsp_err) begin
                desc_q[idx] <= mem_rsp_data;
                idx         <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
            end else if (clean_done && !eoc) begin
                cur_base <= cur_base + ADDR_W'(DESC_BYTES);
                idx      <= '0;
            end
        end
    end

    assign mem_addr    = cur_base + ADDR_W'({idx, 2'b00});
    assign cur_addr    = cur_base;
    assign eng_cmd     = desc_q[0];
    assign eng_bus     = desc_q[1];
    assign eng_tx_addr = {desc_q[3], desc_q[2]};
    assign eng_rx_addr = {desc_q[5], desc_q[4]};

    // R3: start strobe lasts one cycle
    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R3: pending read keeps request and address
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp_valid && !abort_req) |=> (mem_req && $stable(mem_addr)));

    // R7: fetch error ends the chain without dispatch
    p_memerr_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rsp_valid && mem_rsp_err && !abort_req) |=> (!mem_req && !eng_start));

    // R6: abort returns to idle
    p_abort_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && state != S_IDLE) |=> (state == S_IDLE && !mem_req));

    // R4: end-of-chain descriptor stops the walker
    p_eoc_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_done && eoc) |=> (state == S_IDLE));

    // R5: next descriptor fetched 24 bytes further
    p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_done && !eoc) |=> (mem_req && mem_addr == $past(cur_base) + ADDR_W'(DESC_BYTES)));

    // R8: engine fault halts
    p_fault_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && eng_done && !abort_req && eng_fault != '0) |=> (state == S_IDLE));

    // R11: armed start on rising-only trigger waits without an edge
    p_trig_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && trig_rise_en && !trig_fall_en && !vs_rise) |=> !mem_req);

    // R13: current address captured from list base on start
    p_cur_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cur_addr == $past(base_in)));

endmodule

// File: rtl/spi_desc_seq.sv
module spi_desc_seq
    import seq_pkg::*;
#(
    parameter int ADDR_W      = 63,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [5:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rsp_valid,
    input  logic               mem_rsp_err,
    input  logic [31:0]        mem_rsp_data,
    output logic               eng_start,
    output logic [31:0]        eng_cmd,
    output logic [31:0]        eng_bus,
    output logic [63:0]        eng_tx_addr,
    output logic [63:0]        eng_rx_addr,
    input  logic               eng_done,
    input  logic [7:0]         eng_fault,
    input  logic               vsync,
    output logic               irq
);
    logic [STS_W-1:0]  sts_set;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] list_base;
    logic              go_req;
    logic              abort_req;
    logic              trig_rise_en;
    logic              trig_fall_en;
    logic              vs_rise;
    logic              vs_fall;

    seq_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .sts_set      (sts_set),
        .cur_addr     (cur_addr),
        .list_base    (list_base),
        .go_req       (go_req),
        .abort_req    (abort_req),
        .trig_rise_en (trig_rise_en),
        .trig_fall_en (trig_fall_en),
        .irq          (irq)
    );

    seq_vsync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_vsync (
        .clk      (clk),
        .rst_n    (rst_n),
        .vsync_in (vsync),
        .rise     (vs_rise),
        .fall     (vs_fall)
    );

    seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .go_req        (go_req),
        .abort_req     (abort_req),
        .base_in       (list_base),
        .trig_rise_en  (trig_rise_en),
        .trig_fall_en  (trig_fall_en),
        .vs_rise       (vs_rise),
        .vs_fall       (vs_fall),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_err   (mem_rsp_err),
        .mem_rsp_data  (mem_rsp_data),
        .eng_start     (eng_start),
        .eng_cmd       (eng_cmd),
        .eng_bus       (eng_bus),
        .eng_tx_addr   (eng_tx_addr),
        .eng_rx_addr   (eng_rx_addr),
        .eng_done      (eng_done),
        .eng_fault     (eng_fault),
        .sts_set       (sts_set),
        .cur_addr      (cur_addr)
    );

endmodule

// File: tb/spi_desc_seq_tb.sv
module spi_desc_seq_tb;
    localparam int          AW      = 40;
    localparam logic [7:0]  BASE_HI = 8'h5B;
    localparam logic [5:0]  A_SEM = 6'h00, A_CFG = 6'h04, A_LO = 6'h20, A_HI = 6'h24,
                            A_CLO = 6'h28, A_CHI = 6'h2C, A_STS = 6'h30, A_ENA = 6'h34;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic mem_req;
    logic [AW-1:0] mem_addr;
    logic mem_rsp_valid = 1'b0;
    logic mem_rsp_err = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic eng_start;
    logic [31:0] eng_cmd, eng_bus;
    logic [63:0] eng_tx_addr, eng_rx_addr;
    logic eng_done = 1'b0;
    logic [7:0] eng_fault = '0;
    logic vsync = 1'b0;
    logic irq;

    always #2 clk = ~clk;

    spi_desc_seq #(.ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
        .mem_rsp_data(mem_rsp_data), .eng_start(eng_start), .eng_cmd(eng_cmd),
        .eng_bus(eng_bus), .eng_tx_addr(eng_tx_addr), .eng_rx_addr(eng_rx_addr),
        .eng_done(eng_done), .eng_fault(eng_fault), .vsync(vsync), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;

    // scenario knobs, written only by the main sequence
    logic [31:0] mem [256];
    int mem_lat = 0;
    int eng_lat = 0;
    int err_idx = -1;
    int fault_desc = -1;
    logic [7:0] fault_val = 8'h00;

    function automatic logic [31:0] gen(int d, int j, bit last);
        logic [31:0] w;
        w = 32'h1357_0000 ^ (32'(d) * 32'h0001_1111) ^ (32'(j) * 32'h0000_0101);
        if (j == 0) w[30] = last;
        return w;
    endfunction

    // memory model
    int m_cnt = 0;
    always @(negedge clk) begin
        if (mem_rsp_valid) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_err   <= 1'b0;
            m_cnt         <= 0;
        end else if (mem_req) begin
            if (m_cnt >= mem_lat) begin
                int wi;
                wi = int'((mem_addr[31:0] - 32'h100) >> 2);
                mem_rsp_valid <= 1'b1;
                if (mem_addr[39:32] != BASE_HI || mem_addr[31:0] < 32'h100 ||
                    mem_addr[31:0] >= 32'h500 || wi == err_idx) begin
                    mem_rsp_err  <= 1'b1;
                    mem_rsp_data <= 32'hDEAD_BEEF;
                end else begin
                    mem_rsp_err  <= 1'b0;
                    mem_rsp_data <= mem[wi];
                end
            end else m_cnt <= m_cnt + 1;
        end else m_cnt <= 0;
    end

    // engine model and monitors
    int disp = 0;
    int e_cnt = 0;
    logic e_busy = 1'b0;
    int overlap = 0;
    int dbl_start = 0;
    int req_cyc = 0;
    logic prev_start = 1'b0;
    logic [31:0] cap_cmd [16];
    logic [31:0] cap_bus [16];
    logic [63:0] cap_tx [16];
    logic [63:0] cap_rx [16];
    always @(negedge clk) begin
        eng_done  <= 1'b0;
        eng_fault <= 8'h00;
        prev_start <= eng_start;
        if (eng_start && prev_start) dbl_start <= dbl_start + 1;
        if (mem_req) req_cyc <= req_cyc + 1;
        if (mem_req && e_busy) overlap <= overlap + 1;
        if (eng_start) begin
            cap_cmd[disp % 16] <= eng_cmd;
            cap_bus[disp % 16] <= eng_bus;
            cap_tx[disp % 16]  <= eng_tx_addr;
            cap_rx[disp % 16]  <= eng_rx_addr;
            disp   <= disp + 1;
            e_busy <= 1'b1;
            e_cnt  <= eng_lat;
        end else if (e_busy) begin
            if (e_cnt == 0) begin
                eng_done  <= 1'b1;
                eng_fault <= (disp - 1 == fault_desc) ? fault_val : 8'h00;
                e_busy    <= 1'b0;
            end else e_cnt <= e_cnt - 1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_halt();
        logic [31:0] v;
        for (int k = 0; k < 4000; k++) begin
            rd(A_STS, v);
            if (v[9]) break;
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic load_chain(input int n, input int off);
        for (int d = 0; d < n; d++)
            for (int j = 0; j < 6; j++)
                mem[off + 6 * d + j] = gen(d, j, d == n - 1);
    endtask

    task automatic go(input int off);
        wr(A_LO, 32'h100 + 32'(off) * 4);
        wr(A_HI, 32'h8000_0000 | 32'(BASE_HI));
    endtask

    task automatic check_fields(input int d0, input int d, input int n, input string tag);
        int s;
        s = (d0 + d) % 16;
        chk({tag, " R1 cmd"}, 64'(cap_cmd[s]), 64'(gen(d, 0, d == n - 1)));
        chk({tag, " R1 bus"}, 64'(cap_bus[s]), 64'(gen(d, 1, 1'b0)));
        chk({tag, " R1 tx"},  cap_tx[s], {gen(d, 3, 1'b0), gen(d, 2, 1'b0)});
        chk({tag, " R1 rx"},  cap_rx[s], {gen(d, 5, 1'b0), gen(d, 4, 1'b0)});
    endtask

    // watchdog
    initial begin
        #(4 * 190000);
        n_bad++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int d0, off, rq;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(A_SEM, v); chk("R12 sem reset", 64'(v), 64'd1);
        rd(A_STS, v); chk("R9 status reset", 64'(v), 64'd0);
        rd(A_ENA, v); chk("R10 enable reset", 64'(v), 64'd0);
        chk("R10 irq reset", 64'(irq), 64'd0);
        chk("R3 no req at reset", 64'(mem_req), 64'd0);

        // ownership flag
        wr(A_SEM, 32'd0); rd(A_SEM, v); chk("R12 claim", 64'(v), 64'd0);
        wr(A_SEM, 32'd1); rd(A_SEM, v); chk("R12 release", 64'(v), 64'd1);
        wr(A_SEM, 32'd2); rd(A_SEM, v); chk("R12 only bit0", 64'(v), 64'd0);
        wr(A_SEM, 32'd1);

        wr(A_ENA, 32'hFFF);

        // sweep: chain length x memory latency x engine latency
        for (int n = 1; n <= 4; n++)
            for (int ml = 0; ml <= 2; ml++)
                for (int el = 0; el <= 2; el++) begin
                    off = (n * 5 + ml * 3 + el) % 16;
                    load_chain(n, off);
                    mem_lat = ml;
                    eng_lat = el;
                    d0 = disp;
                    go(off);
                    wait_halt();
                    chk("R4 R5 dispatched count", 64'(disp - d0), 64'(n));
                    for (int d = 0; d < n; d++) check_fields(d0, d, n, "sweep");
                    rd(A_STS, v); chk("R4 R5 status", 64'(v), 64'h0E00);
                    chk("R10 irq on", 64'(irq), 64'd1);
                    rd(A_CLO, v);
                    chk("R13 cur lo", 64'(v), 64'(32'h100 + 32'(off) * 4 + 32'(24 * (n - 1))));
                    rd(A_CHI, v); chk("R13 cur hi", 64'(v), 64'(BASE_HI));
                    chk("R3 no fetch while engine busy", 64'(overlap), 64'd0);
                    chk("R3 single-cycle start", 64'(dbl_start), 64'd0);
                    wr(A_STS, 32'hFFF);
                    rd(A_STS, v); chk("R9 clear all", 64'(v), 64'd0);
                    chk("R10 irq off", 64'(irq), 64'd0);
                end
        mem_lat = 1;
        eng_lat = 1;

        // fetch error inside descriptor 1
        load_chain(3, 40);
        err_idx = 40 + 6 + 3;
        d0 = disp;
        go(40);
        wait_halt();
        chk("R7 dispatched before error", 64'(disp - d0), 64'd1);
        rd(A_STS, v); chk("R7 status", 64'(v), 64'h0700);
        err_idx = -1;
        wr(A_STS, 32'h100);
        rd(A_STS, v); chk("R9 partial clear", 64'(v), 64'h0600);

        // interrupt mask
        wr(A_ENA, 32'h000); #1; chk("R10 masked", 64'(irq), 64'd0);
        wr(A_ENA, 32'h400); #1; chk("R10 one bit", 64'(irq), 64'd1);
        wr(A_ENA, 32'h100); #1; chk("R10 cleared bit", 64'(irq), 64'd0);
        wr(A_ENA, 32'hFFF);
        wr(A_STS, 32'hFFF);

        // engine fault on descriptor 1
        load_chain(3, 60);
        d0 = disp;
        fault_desc = d0 + 1;
        fault_val  = 8'h5A;
        go(60);
        wait_halt();
        chk("R8 dispatched", 64'(disp - d0), 64'd2);
        rd(A_STS, v); chk("R8 status", 64'(v), 64'h065A);
        fault_desc = -1;
        wr(A_STS, 32'hFFF);

        // abort during a long engine run
        load_chain(4, 80);
        eng_lat = 40;
        d0 = disp;
        go(80);
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            if (disp - d0 >= 1) break;
        end
        repeat (3) @(negedge clk);
        wr(A_HI, 32'd0);
        rq = req_cyc;
        repeat (100) @(negedge clk);
        chk("R6 one dispatch only", 64'(disp - d0), 64'd1);
        chk("R6 no fetch after abort", 64'(req_cyc - rq), 64'd0);
        rd(A_STS, v); chk("R6 status", 64'(v), 64'h0200);
        wr(A_STS, 32'hFFF);

        // go while busy is ignored
        load_chain(2, 110);
        eng_lat = 20;
        d0 = disp;
        go(110);
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            if (disp - d0 >= 1) break;
        end
        wr(A_LO, 32'h100 + 32'd130 * 4);
        wr(A_HI, 32'h8000_0000 | 32'(BASE_HI));
        wait_halt();
        repeat (60) @(negedge clk);
        chk("R2 busy go ignored count", 64'(disp - d0), 64'd2);
        check_fields(d0, 1, 2, "R2 busy");
        rd(A_CLO, v); chk("R2 R13 base kept", 64'(v), 64'(32'h100 + 32'd110 * 4 + 32'd24));
        wr(A_STS, 32'hFFF);
        eng_lat = 1;

        // rising-edge trigger
        load_chain(1, 140);
        wr(A_CFG, 32'h40);
        d0 = disp;
        rq = req_cyc;
        go(140);
        repeat (30) @(negedge clk);
        chk("R11 rise waits", 64'(req_cyc - rq), 64'd0);
        vsync = 1'b1;
        wait_halt();
        chk("R11 rise started", 64'(disp - d0), 64'd1);
        rd(A_STS, v); chk("R11 rise status", 64'(v), 64'h0E00);
        wr(A_STS, 32'hFFF);

        // falling-edge trigger; a rising edge must not start it
        vsync = 1'b0;
        repeat (10) @(negedge clk);
        wr(A_CFG, 32'h80);
        d0 = disp;
        rq = req_cyc;
        go(140);
        repeat (20) @(negedge clk);
        vsync = 1'b1;
        repeat (20) @(negedge clk);
        chk("R11 fall ignores rise", 64'(req_cyc - rq), 64'd0);
        vsync = 1'b0;
        wait_halt();
        chk("R11 fall started", 64'(disp - d0), 64'd1);
        check_fields(d0, 0, 1, "R11 fall");
        wr(A_CFG, 32'h0);
        wr(A_STS, 32'hFFF);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule